// File: doc/BRIEF.md
# Compare-Match Timer Channel

One 16-bit timer channel behind an 8-bit register bus. The counter advances on ticks from an internal prescaler (divide by 1, 4, 16, 64, 256 or 1024 of the system clock) or on synchronised edges of an external count input. It only advances while this channel's bit in the run register is set and the mode field selects plain counting.

When the counter equals the compare register on a tick, a match occurs. A match raises a status flag and may drive an interrupt. It also applies a configured action to an output pin, and it may return the counter to zero so the channel runs periodically. Software acknowledges the flag with a read of the status register followed by a write of zero to the flag bit.

The register map, byte address on `bus_addr`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | mode |
| 2 | pin control |
| 3 | interrupt enable |
| 4 | status |
| 5 | run |
| 6 / 7 | counter low / high byte |
| 8 / 9 | compare low / high byte |

Top module: `cmt_channel`

## Requirements
- R1: After reset every register reads 0, `cmp_pin` is 0 and `irq` is 0.
- R2: With control bits [2:0] at 0, 1, 2, 3, 6 or 7, the counter advances once every 1, 4, 16, 64, 256 or 1024 clocks. Counting starts from the edge that sets the run bit. After the run bit has been high for s edges (the clearing edge included), the counter has advanced by floor(s/N).
- R3: With control bits [2:0] at 4 or 5, the counter advances on edges of `ext_clk`. Control bits [4:3] select the edge: 0 counts rising edges, 1 counts falling edges, 2 or 3 count both.
- R4: The counter advances only while run register bit 0 (the channel index) is 1. While that bit is 0, the counter keeps its value, including across external edges.
- R5: Any mode register value with bits [3:0] not zero stops counting.
- R6: Control bits [7:5] equal to 1 return the counter to 0 on a match tick, so the period is compare+1 ticks. Any other code never clears the counter, and the counter wraps from 0xFFFF to 0.
- R7: Status bit 0 becomes 1 on the tick on which the counter equals the compare register, with or without clearing.
- R8: A write to the status register with bit 0 at 0 clears the flag only if a status read that saw the flag at 1 came before it. A write with bit 0 at 1, or without such a read, leaves the flag at 1.
- R9: A match in the same cycle as an acknowledging write leaves the flag at 1.
- R10: `irq` is 1 exactly while status bit 0 and interrupt-enable bit 0 are both 1.
- R11: A write to the pin control register sets `cmp_pin` to 0 for low-nibble codes 1 to 3 and to 1 for codes 5 to 7. Any other code leaves the pin unchanged.
- R12: On a match the pin is cleared for codes 1 and 5, set for codes 2 and 6, toggled for codes 3 and 7, and left unchanged for code 0.
- R13: A write to a counter byte replaces that byte and suppresses the increment in that cycle. The other byte is kept.
- R14: Reads return the addressed register on `bus_rdata` one clock after `bus_rd`. Status bits [7:1] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_clk | input | 1 | External count input (asynchronous) |
| cmp_pin | output | 1 | Compare output pin |
| irq | output | 1 | Match interrupt request |

## Verification
The hardest case to reach from the ports is a match tick that lands on the same clock edge as the acknowledging status write. That write only counts when an armed read came before it.

The bench runs the counter at divide-by-one with a compare value of 4, so matches fall on every fifth edge after the run bit is set. It places the arming read one edge after the first match and schedules the zero write for the exact edge of the second match, then checks that the flag survived.

Sweeps over compare values, run lengths, prescaler codes, clear-source codes, edge modes and pin codes cover the periodic and free-running arithmetic.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int PSC_W = 10;

  // register byte addresses
  localparam int A_CTRL   = 0;
  localparam int A_MODE   = 1;
  localparam int A_PINCTL = 2;
  localparam int A_IRQEN  = 3;
  localparam int A_FLAGS  = 4;
  localparam int A_RUN    = 5;
  localparam int A_CNT    = 6;

  localparam logic [2:0] CLR_ON_A  = 3'd1;
  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  // terminal value of the prescale divider (divisor - 1)
  function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] sel);
    case (sel)
      3'd1:    return PSC_W'(3);
      3'd2:    return PSC_W'(15);
      3'd3:    return PSC_W'(63);
      3'd6:    return PSC_W'(255);
      3'd7:    return PSC_W'(1023);
      default: return PSC_W'(0);
    endcase
  endfunction

  function automatic logic psc_is_ext(input logic [2:0] sel);
    return (sel == 3'd4) || (sel == 3'd5);
  endfunction

  function automatic logic pin_has_init(input logic [3:0] code);
    return !code[3] && (code[1:0] != 2'd0);
  endfunction

  function automatic pin_act_e pin_action(input logic [3:0] code);
    if (code[3] || code[1:0] == 2'd0) return ACT_NONE;
    return pin_act_e'(code[1:0]);
  endfunction

endpackage

// File: rtl/cmt_tick_gen.sv
module cmt_tick_gen
  import cmt_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_en,
  input  logic [2:0] psc_sel,
  input  logic [1:0] edge_sel,
  input  logic       ext_in,
  output logic       tick
);

  logic [SYNC_N:0]    ext_q;
  logic [PSC_W-1:0]   div_q;
  logic [PSC_W-1:0]   lim;
  logic               is_ext;
  logic               rise;
  logic               fall;
  logic               ext_hit;
  logic               int_hit;

  assign is_ext = psc_is_ext(psc_sel);
  assign lim    = psc_limit(psc_sel);

  // synchroniser plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) ext_q <= '0;
    else     ext_q <= {ext_q[SYNC_N-1:0], ext_in};
  end

  assign rise = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];
  assign fall = ~ext_q[SYNC_N-1] & ext_q[SYNC_N];

  always_comb begin
    case (edge_sel)
      EDGE_RISE: ext_hit = rise;
      EDGE_FALL: ext_hit = fall;
      default:   ext_hit = rise | fall;
    endcase
  end

  assign int_hit = (div_q >= lim);

  // divider restarts whenever the channel is idle or fed externally
  always_ff @(posedge clk) begin
    if (rst || !run_en || is_ext) div_q <= '0;
    else if (int_hit)             div_q <= '0;
    else                          div_q <= div_q + PSC_W'(1);
  end

  assign tick = run_en && (is_ext ? ext_hit : int_hit);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        clr_on_match,
  input  logic [CNT_W/DATA_W-1:0]     lane_wr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [CNT_W-1:0]            cmp,
  output logic [CNT_W-1:0]            cnt,
  output logic                        match
);

  localparam int LANES = CNT_W / DATA_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign match = tick && (cnt_q == cmp);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (match && clr_on_match) cnt_d = '0;
      else                       cnt_d = cnt_q + CNT_W'(1);
    end
    // a bus write to any byte wins over the increment
    if (|lane_wr) begin
      cnt_d = cnt_q;
      for (int i = 0; i < LANES; i++) begin
        if (lane_wr[i]) cnt_d[i*DATA_W +: DATA_W] = wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cmt_pin.sv
module cmt_pin
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [3:0] new_code,
  input  logic [3:0] cur_code,
  input  logic       match,
  output logic       pin
);

  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (cfg_wr) begin
      if (pin_has_init(new_code)) pin_q <= new_code[2];
    end else if (match) begin
      case (pin_action(cur_code))
        ACT_CLR: pin_q <= 1'b0;
        ACT_SET: pin_q <= 1'b1;
        ACT_TGL: pin_q <= ~pin_q;
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pin = pin_q;

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  output logic              cmp_pin,
  output logic              irq
);

  localparam int LANES      = CNT_W / DATA_W;
  localparam int A_CMP_BASE = A_CNT + LANES;

  logic [DATA_W-1:0] ctrl_q, mode_q, pinctl_q, irqen_q, run_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  cnt;
  logic              flag_q, arm_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic [LANES-1:0]  cnt_lane_wr, cmp_lane_wr;
  logic              ctrl_wr, mode_wr, pin_wr, irqen_wr, flag_wr, run_wr, flag_rd;
  logic              run_bit, run_en, tick, match;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign mode_wr  = bus_wr && (bus_addr == ADDR_W'(A_MODE));
  assign pin_wr   = bus_wr && (bus_addr == ADDR_W'(A_PINCTL));
  assign irqen_wr = bus_wr && (bus_addr == ADDR_W'(A_IRQEN));
  assign flag_wr  = bus_wr && (bus_addr == ADDR_W'(A_FLAGS));
  assign run_wr   = bus_wr && (bus_addr == ADDR_W'(A_RUN));
  assign flag_rd  = bus_rd && (bus_addr == ADDR_W'(A_FLAGS));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cnt_lane_wr[g] = bus_wr && (bus_addr == ADDR_W'(A_CNT + g));
    assign cmp_lane_wr[g] = bus_wr && (bus_addr == ADDR_W'(A_CMP_BASE + g));
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      pinctl_q <= '0;
      irqen_q  <= '0;
      run_q    <= '0;
      cmp_q    <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q   <= bus_wdata;
      if (mode_wr)  mode_q   <= bus_wdata;
      if (pin_wr)   pinctl_q <= bus_wdata;
      if (irqen_wr) irqen_q  <= bus_wdata;
      if (run_wr)   run_q    <= bus_wdata;
      for (int i = 0; i < LANES; i++) begin
        if (cmp_lane_wr[i]) cmp_q[i*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  assign run_bit = run_q[CH_IDX];
  assign run_en  = run_bit && (mode_q[3:0] == 4'd0);

  cmt_tick_gen u_tick (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .psc_sel  (ctrl_q[2:0]),
    .edge_sel (ctrl_q[4:3]),
    .ext_in   (ext_clk),
    .tick     (tick)
  );

  cmt_counter #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .clr_on_match (ctrl_q[7:5] == CLR_ON_A),
    .lane_wr      (cnt_lane_wr),
    .wdata        (bus_wdata),
    .cmp          (cmp_q),
    .cnt          (cnt),
    .match        (match)
  );

  cmt_pin u_pin (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (pin_wr),
    .new_code (bus_wdata[3:0]),
    .cur_code (pinctl_q[3:0]),
    .match    (match),
    .pin      (cmp_pin)
  );

  // match flag: hardware set beats an armed software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (match)                                  flag_q <= 1'b1;
      else if (flag_wr && arm_q && !bus_wdata[0]) flag_q <= 1'b0;
      if (flag_wr)                 arm_q <= 1'b0;
      else if (flag_rd && flag_q)  arm_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL))   rd_mux = ctrl_q;
    if (bus_addr == ADDR_W'(A_MODE))   rd_mux = mode_q;
    if (bus_addr == ADDR_W'(A_PINCTL)) rd_mux = pinctl_q;
    if (bus_addr == ADDR_W'(A_IRQEN))  rd_mux = irqen_q;
    if (bus_addr == ADDR_W'(A_FLAGS))  rd_mux = DATA_W'(flag_q);
    if (bus_addr == ADDR_W'(A_RUN))    rd_mux = run_q;
    for (int i = 0; i < LANES; i++) begin
      if (bus_addr == ADDR_W'(A_CNT + i))      rd_mux = cnt[i*DATA_W +: DATA_W];
      if (bus_addr == ADDR_W'(A_CMP_BASE + i)) rd_mux = cmp_q[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = flag_q && irqen_q[0];

endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    run_bit,
  input logic [3:0]              mode_sel,
  input logic [2:0]              clr_sel,
  input logic [2:0]              psc_sel,
  input logic                    ctrl_wr,
  input logic                    tick,
  input logic [CNT_W-1:0]        cnt,
  input logic [CNT_W-1:0]        cmp,
  input logic [CNT_W/DATA_W-1:0] lane_wr,
  input logic [DATA_W-1:0]       wdata,
  input logic                    flag,
  input logic                    flag_wr
);

  // R2
  prescaled_tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && psc_sel != 3'd0 && psc_sel != 3'd4 && psc_sel != 3'd5 && !ctrl_wr) |=> !tick);

  // R4
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_bit && !(|lane_wr)) |=> $stable(cnt));

  // R5
  hold_other_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != 4'd0 && !(|lane_wr)) |=> $stable(cnt));

  // R6
  clear_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == cmp && clr_sel == 3'd1 && !(|lane_wr)) |=> (cnt == '0));

  // R7
  flag_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == cmp) |=> flag);

  // R8
  flag_fall_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(flag_wr));

  // R13
  low_byte_write_chk: assert property (@(posedge clk) disable iff (rst)
    lane_wr[0] |=> (cnt[DATA_W-1:0] == $past(wdata)));

endmodule

bind cmt_channel cmt_channel_chk #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_bit  (run_bit),
  .mode_sel (mode_q[3:0]),
  .clr_sel  (ctrl_q[7:5]),
  .psc_sel  (ctrl_q[2:0]),
  .ctrl_wr  (ctrl_wr),
  .tick     (tick),
  .cnt      (cnt),
  .cmp      (cmp_q),
  .lane_wr  (cnt_lane_wr),
  .wdata    (bus_wdata),
  .flag     (flag_q),
  .flag_wr  (flag_wr)
);

// File: tb/cmt_channel_tb.sv
module cmt_channel_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] R_CTRL = 4'd0, R_MODE = 4'd1, R_PIN = 4'd2, R_IEN = 4'd3,
                         R_FLG = 4'd4, R_RUN = 4'd5, R_CNTL = 4'd6, R_CNTH = 4'd7,
                         R_CMPL = 4'd8, R_CMPH = 4'd9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic       cmp_pin;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_channel u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge; each wr/rd spans one rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_cnt(output int v);
    int lo, hi;
    rd(R_CNTL, lo);
    rd(R_CNTH, hi);
    v = hi * 256 + lo;
  endtask

  task automatic setup(input logic [7:0] ctrl, input logic [15:0] cmpv);
    int d;
    wr(R_CTRL, ctrl);
    wr(R_CMPL, cmpv[7:0]);
    wr(R_CMPH, cmpv[15:8]);
    wr(R_CNTL, 8'h00);
    wr(R_CNTH, 8'h00);
    rd(R_FLG, d);
    wr(R_FLG, 8'h00);
  endtask

  task automatic run_for(input int s);
    wr(R_RUN, 8'h01);
    idle(s - 1);
    wr(R_RUN, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int d, v, e;
    int divs [6] = '{1, 4, 16, 64, 256, 1024};
    int codes[6] = '{0, 1, 2, 3, 6, 7};
    int pcodes[6] = '{1, 2, 3, 5, 6, 7};
    int ccodes[5] = '{0, 2, 3, 5, 6};

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R14: reset values through the bus
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check("R1", $sformatf("reset read addr %0d", a), d, 0);
    end
    check("R1", "reset pin", int'(cmp_pin), 0);
    check("R1", "reset irq", int'(irq), 0);
    wr(R_CMPL, 8'hA5);
    rd(R_CMPL, d);
    check("R14", "compare low readback", d, 8'hA5);

    // R2: prescaler sweep, no clearing, compare out of reach
    for (int k = 0; k < 6; k++) begin
      for (int t = 0; t < 2; t++) begin
        int s = (t == 0) ? divs[k] - 1 : 2 * divs[k] + 1;
        if (s < 1) continue;
        setup(8'(codes[k]), 16'hFFFF);
        run_for(s);
        rd_cnt(v);
        check("R2", $sformatf("psc code %0d edges %0d", codes[k], s), v, s / divs[k]);
      end
    end

    // R6 / R7: periodic sweep over compare values and run lengths
    for (int c = 0; c < 6; c++) begin
      for (int s = 1; s <= 13; s++) begin
        setup(8'h20, 16'(c));
        run_for(s);
        rd_cnt(v);
        check("R6", $sformatf("clear-on-A cmp %0d edges %0d", c, s), v, s % (c + 1));
        rd(R_FLG, d);
        check("R7", $sformatf("flag cmp %0d edges %0d", c, s), d, (s >= c + 1) ? 1 : 0);
      end
    end

    // R6 / R7: other clear-source codes never clear
    for (int k = 0; k < 5; k++) begin
      setup(8'(ccodes[k] << 5), 16'd2);
      run_for(5);
      rd_cnt(v);
      check("R6", $sformatf("clear code %0d no clear", ccodes[k]), v, 5);
      rd(R_FLG, d);
      check("R7", $sformatf("clear code %0d flag", ccodes[k]), d, 1);
    end

    // R6: wrap from 0xFFFF to 0
    setup(8'h00, 16'd3);
    wr(R_CNTL, 8'hFE);
    wr(R_CNTH, 8'hFF);
    run_for(3);
    rd_cnt(v);
    check("R6", "wrap past 0xFFFF", v, 1);

    // R13: write wins over increment; R4: value held when stopped
    setup(8'h00, 16'hFFFF);
    wr(R_RUN, 8'h01);
    idle(2);
    wr(R_CNTL, 8'h40);
    idle(2);
    wr(R_RUN, 8'h00);
    rd_cnt(v);
    check("R13", "counter byte write priority", v, 16'h0043);
    idle(10);
    rd_cnt(v);
    check("R4", "counter held while stopped", v, 16'h0043);

    // R13: carry into high byte after low byte write
    setup(8'h00, 16'hFFFF);
    wr(R_CNTL, 8'hFE);
    run_for(3);
    rd_cnt(v);
    check("R13", "carry after byte write", v, 16'h0101);

    // R5: non-normal mode does not count
    wr(R_MODE, 8'h02);
    setup(8'h00, 16'hFFFF);
    run_for(10);
    rd_cnt(v);
    check("R5", "mode 2 holds counter", v, 0);
    wr(R_MODE, 8'h00);

    // R3: external clock, each edge mode, codes 4 and 5
    for (int p = 4; p <= 5; p++) begin
      for (int eg = 0; eg < 4; eg++) begin
        setup(8'((eg << 3) | p), 16'hFFFF);
        wr(R_RUN, 8'h01);
        for (int i = 0; i < 3; i++) begin
          ext_clk = 1'b1; idle(3);
          ext_clk = 1'b0; idle(3);
        end
        idle(4);
        wr(R_RUN, 8'h00);
        rd_cnt(v);
        e = (eg < 2) ? 3 : 6;
        check("R3", $sformatf("ext code %0d edge mode %0d", p, eg), v, e);
      end
    end
    // R4: external edges while stopped are not counted
    for (int i = 0; i < 2; i++) begin
      ext_clk = 1'b1; idle(3);
      ext_clk = 1'b0; idle(3);
    end
    idle(4);
    rd_cnt(v);
    check("R4", "ext edges while stopped", v, 6);

    // R8 / R10: acknowledge protocol and interrupt gating
    setup(8'h20, 16'd2);
    run_for(3);
    wr(R_IEN, 8'h01);
    check("R10", "irq with flag and enable", int'(irq), 1);
    wr(R_IEN, 8'h00);
    check("R10", "irq masked", int'(irq), 0);
    wr(R_IEN, 8'h01);
    wr(R_FLG, 8'h00);
    rd(R_FLG, d);
    check("R8", "zero write without read ignored", d, 1);
    wr(R_FLG, 8'h01);
    rd(R_FLG, d);
    check("R8", "write of one keeps flag", d, 1);
    wr(R_FLG, 8'h00);
    check("R10", "irq drops after ack", int'(irq), 0);
    rd(R_FLG, d);
    check("R8", "read then zero write clears", d, 0);
    wr(R_IEN, 8'h00);

    // R9: armed clear lands on the match edge
    setup(8'h20, 16'd4);
    wr(R_RUN, 8'h01);
    idle(5);
    rd(R_FLG, d);
    check("R7", "flag after first match", d, 1);
    idle(3);
    wr(R_FLG, 8'h00);
    wr(R_RUN, 8'h00);
    rd(R_FLG, d);
    check("R9", "set wins over clear", d, 1);
    rd_cnt(v);
    check("R6", "count after set-wins run", v, 1);

    // R11 / R12: pin codes
    for (int k = 0; k < 6; k++) begin
      int init, p1, p2, act;
      setup(8'h20, 16'd2);
      wr(R_PIN, 8'(pcodes[k]));
      init = (pcodes[k] >= 5) ? 1 : 0;
      check("R11", $sformatf("pin init code %0d", pcodes[k]), int'(cmp_pin), init);
      act = pcodes[k] & 3;
      p1 = (act == 1) ? 0 : (act == 2) ? 1 : 1 - init;
      p2 = (act == 1) ? 0 : (act == 2) ? 1 : init;
      run_for(4);
      check("R12", $sformatf("pin after 1 match code %0d", pcodes[k]), int'(cmp_pin), p1);
      run_for(3);
      check("R12", $sformatf("pin after 2 matches code %0d", pcodes[k]), int'(cmp_pin), p2);
    end
    wr(R_PIN, 8'h06);
    wr(R_PIN, 8'h00);
    check("R11", "code 0 keeps pin", int'(cmp_pin), 1);
    setup(8'h20, 16'd2);
    run_for(4);
    check("R12", "code 0 no match action", int'(cmp_pin), 1);
    wr(R_PIN, 8'h01);
    wr(R_PIN, 8'h0C);
    check("R11", "code 12 keeps pin", int'(cmp_pin), 0);

    // R14: unused status bits read zero
    rd(R_FLG, d);
    check("R14", "status upper bits", d & 8'hFE, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule